// File: doc/BRIEF.md
# Byte-Lane Write Decode and Bus Direction Control

This block sits between the address sequencer of a synchronous SRAM that uses one bus for both read and write data, and the storage array behind it. On every clock edge it reads the active-low write controls: a global write, a byte-write enable and one select per byte lane. It combines them with the type of access the sequencer reports for that edge. From these it works out which byte lanes of the word are written. Each lane holds 8 data bits and one parity bit. The lane enables and the write data are registered on that edge and passed to the array one cycle later. Because the array write follows from the registered command, the write times itself.

The same block controls the direction of the shared data bus. It drives the bus only when the previous edge was a read and the asynchronous active-low output enable is low. It releases the bus as soon as the current inputs show a write, even if the output enable is still low.

Top module: `byte_write_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wr_en` is all zero and `bus_oe` is low.
- R2: On an edge with an active access other than a processor-strobe start, a low `gw_n` sets every bit of `wr_en` in the next cycle. The values of `bwe_n` and `bsel_n` have no effect.
- R3: On such an edge, with `gw_n` high and `bwe_n` low, `wr_en[b]` in the next cycle equals the inverse of `bsel_n[b]`. When all selects are high, no lane is written and the edge counts as a read.
- R4: On such an edge, with `gw_n` and `bwe_n` both high, `wr_en` is zero in the next cycle and the edge counts as a read.
- R5: On an edge where `acc_start_p` is high, `wr_en` is zero in the next cycle whatever the write inputs are, and the edge counts as a read. This takes priority over `acc_start_c`.
- R6: A controller-strobe start (`acc_start_c` high, `acc_start_p` low) whose write inputs show a write produces that write on its own edge. The lane enables appear in the very next cycle.
- R7: On an edge with none of `acc_start_p`, `acc_start_c`, `acc_cont` high, nothing is written and nothing is read. `wr_en` is zero and `bus_oe` is low in the next cycle.
- R8: For each lane b written on an edge, `wr_data` takes two fields from `din` in the next cycle: bits [8b+7:8b] and parity bit 16+b. A lane that is not written keeps its previous value in `wr_data`.
- R9: `bus_oe` is high only when the previous edge was a read and `oe_n` is low. It follows `oe_n` within the same cycle, with no clock in between.
- R10: `bus_oe` is low whenever the current inputs show a write, that is, an active access other than a processor-strobe start whose decode selects at least one lane. This holds even when `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | NB | Per-lane byte selects, active low |
| acc_start_p | input | 1 | Access started by the processor strobe on this edge |
| acc_start_c | input | 1 | Access started by the controller strobe on this edge |
| acc_cont | input | 1 | Burst continues or holds on this edge |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | NB*(BYTE_W+1) | Write data from the bus: data lanes low, parity bits on top |
| wr_en | output | NB | Registered per-lane array write enables |
| wr_data | output | NB*(BYTE_W+1) | Registered write data for the array |
| bus_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The bench builds the block with its defaults: two lanes of 8 data bits plus parity. With two lanes, the whole space of write-control inputs has only 16 points. The bench drives all of them under each of the three access types, and with the output enable both high and low. This covers the global-write override, the single-lane writes and the all-deselected read. It also checks the processor-start block against controller-start writes on the very same input values. The lane data and parity fields use fresh data on every edge, so a lane that leaks or a parity bit that lands in the wrong lane shows up in `wr_data`.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2
  } cyc_kind_t;
endpackage

// File: rtl/bwc_decode.sv
module bwc_decode
  import bwc_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bsel_n,
  input  logic          start_p,
  input  logic          start_c,
  input  logic          cont,
  output logic [NB-1:0] mask,
  output cyc_kind_t     kind
);
  logic active;
  logic [NB-1:0] raw_mask;

  assign active = start_p | start_c | cont;

  always_comb begin
    if (!gw_n)       raw_mask = '1;
    else if (!bwe_n) raw_mask = ~bsel_n;
    else             raw_mask = '0;
  end

  always_comb begin
    mask = '0;
    kind = CK_NONE;
    if (active) begin
      if (start_p || raw_mask == '0) begin
        kind = CK_READ;
      end else begin
        kind = CK_WRITE;
        mask = raw_mask;
      end
    end
  end
endmodule

// File: rtl/bwc_lane_reg.sv
module bwc_lane_reg
  import bwc_pkg::*;
#(
  parameter int NB     = 2,
  parameter int BYTE_W = 8,
  localparam int DW    = NB * BYTE_W,
  localparam int W     = NB * (BYTE_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] mask,
  input  cyc_kind_t     kind,
  input  logic [W-1:0]  din,
  output logic [NB-1:0] wr_en,
  output logic [W-1:0]  wr_data,
  output logic          rd_q
);
  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= (kind == CK_READ);
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        wr_en[b]                    <= 1'b0;
        wr_data[b*BYTE_W +: BYTE_W] <= '0;
        wr_data[DW + b]             <= 1'b0;
      end else begin
        wr_en[b] <= mask[b];
        if (mask[b]) begin
          wr_data[b*BYTE_W +: BYTE_W] <= din[b*BYTE_W +: BYTE_W];
          wr_data[DW + b]             <= din[DW + b];
        end
      end
    end
  end
endmodule

// File: rtl/bwc_dir_ctrl.sv
module bwc_dir_ctrl
  import bwc_pkg::*;
(
  input  logic      rd_q,
  input  logic      oe_n,
  input  cyc_kind_t kind,
  output logic      bus_oe
);
  assign bus_oe = rd_q & ~oe_n & (kind != CK_WRITE);
endmodule

// File: rtl/byte_write_ctrl.sv
module byte_write_ctrl
  import bwc_pkg::*;
#(
  parameter int NB     = 2,
  parameter int BYTE_W = 8,
  localparam int W     = NB * (BYTE_W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bsel_n,
  input  logic          acc_start_p,
  input  logic          acc_start_c,
  input  logic          acc_cont,
  input  logic          oe_n,
  input  logic [W-1:0]  din,
  output logic [NB-1:0] wr_en,
  output logic [W-1:0]  wr_data,
  output logic          bus_oe
);
  logic [NB-1:0] mask;
  cyc_kind_t     kind;
  logic          rd_q;

  bwc_decode #(.NB(NB)) i_decode (
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .start_p(acc_start_p), .start_c(acc_start_c), .cont(acc_cont),
    .mask(mask), .kind(kind)
  );

  bwc_lane_reg #(.NB(NB), .BYTE_W(BYTE_W)) i_lanes (
    .clk(clk), .rst(rst), .mask(mask), .kind(kind), .din(din),
    .wr_en(wr_en), .wr_data(wr_data), .rd_q(rd_q)
  );

  bwc_dir_ctrl i_dir (
    .rd_q(rd_q), .oe_n(oe_n), .kind(kind), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/bwc_chk.sv
module bwc_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          gw_n,
  input logic          bwe_n,
  input logic [NB-1:0] bsel_n,
  input logic          acc_start_p,
  input logic          acc_start_c,
  input logic          acc_cont,
  input logic          oe_n,
  input logic [NB-1:0] wr_en,
  input logic          bus_oe
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
    (!acc_start_p && (acc_start_c || acc_cont) && !gw_n) |=> (wr_en == {NB{1'b1}})); // R2

  AST_BYTE_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!acc_start_p && (acc_start_c || acc_cont) && gw_n && !bwe_n) |=> (wr_en == ~$past(bsel_n))); // R3

  AST_PSTART_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    acc_start_p |=> (wr_en == '0)); // R5

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!acc_start_p && !acc_start_c && !acc_cont) |=> (wr_en == '0 && !bus_oe)); // R7

  AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (rst || !past_ok)
    bus_oe |-> (!oe_n && wr_en == '0)); // R9

  AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    (!acc_start_p && (acc_start_c || acc_cont) && !gw_n) |-> !bus_oe); // R10
endmodule

bind byte_write_ctrl bwc_chk #(.NB(NB)) i_bwc_chk (
  .clk(clk), .rst(rst), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
  .acc_start_p(acc_start_p), .acc_start_c(acc_start_c), .acc_cont(acc_cont),
  .oe_n(oe_n), .wr_en(wr_en), .bus_oe(bus_oe)
);

// File: tb/test_byte_write_ctrl.sv
module test_byte_write_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int BYTE_W = 8;
  localparam int DW = NB * BYTE_W;
  localparam int W = NB * (BYTE_W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [NB-1:0] bsel_n = '1;
  logic acc_start_p = 1'b0, acc_start_c = 1'b0, acc_cont = 1'b0;
  logic oe_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [NB-1:0] wr_en;
  logic [W-1:0] wr_data;
  logic bus_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [NB-1:0] en;
    logic [W-1:0]  data;
    string         tag;
  } item_t;
  item_t sb[$];

  logic          m_rd = 1'b0;
  logic [W-1:0]  m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_write_ctrl #(.NB(NB), .BYTE_W(BYTE_W)) i_byte_write_ctrl (
    .clk(clk), .rst(rst), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .acc_start_p(acc_start_p), .acc_start_c(acc_start_c), .acc_cont(acc_cont),
    .oe_n(oe_n), .din(din), .wr_en(wr_en), .wr_data(wr_data), .bus_oe(bus_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per rising edge, samples away from the edge
  always @(posedge clk) begin
    if (!rst && sb.size() > 0) begin
      item_t it;
      #2;
      it = sb.pop_front();
      check(it.tag, W'(wr_en), W'(it.en));
      check("R8", wr_data, it.data);
    end
  end

  // driver: called just after a falling edge
  task automatic drive(input logic p, input logic c, input logic k, input logic g,
                       input logic be, input logic [NB-1:0] bs, input logic oe);
    logic active, wr_now;
    logic [NB-1:0] raw, msk;
    logic [W-1:0] d;
    item_t it;
    d = W'({$urandom, $urandom});
    acc_start_p = p; acc_start_c = c; acc_cont = k;
    gw_n = g; bwe_n = be; bsel_n = bs; oe_n = oe; din = d;
    active = p | c | k;
    raw = !g ? '1 : (!be ? ~bs : '0);
    msk = (active && !p) ? raw : '0;
    wr_now = (msk != '0);
    #1;
    check(wr_now ? "R10" : "R9", W'(bus_oe), W'(m_rd & ~oe & ~wr_now));
    for (int b = 0; b < NB; b++)
      if (msk[b]) begin
        m_data[b*BYTE_W +: BYTE_W] = d[b*BYTE_W +: BYTE_W];
        m_data[DW + b] = d[DW + b];
      end
    it.en = msk;
    it.data = m_data;
    if (!active) it.tag = "R7";
    else if (p) it.tag = "R5";
    else if (c && wr_now) it.tag = "R6";
    else if (!g) it.tag = "R2";
    else if (!be) it.tag = "R3";
    else it.tag = "R4";
    sb.push_back(it);
    m_rd = active && !wr_now;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    oe_n = 1'b0;
    #1;
    check("R1", W'(wr_en), '0);
    check("R1", W'(bus_oe), '0);
    check("R1", wr_data, '0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R1", W'(bus_oe), '0);
    @(negedge clk);
    // exhaustive write-control combinations under each access type, both oe_n levels
    for (int acc = 0; acc < 3; acc++)
      for (int oe = 0; oe < 2; oe++)
        for (int v = 0; v < 16; v++) begin
          drive(acc == 0, acc == 1, acc == 2, v[3], v[2], v[1:0], oe[0]);
          drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0);
        end
    // processor start has priority over controller start
    for (int v = 0; v < 16; v++)
      drive(1'b1, 1'b1, 1'b0, v[3], v[2], v[1:0], 1'b0);
    // idle edges after a read and after a write
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0);
    // asynchronous oe_n toggle within one read cycle
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 1'b1);
    oe_n = 1'b0; #1; check("R9", W'(bus_oe), W'(1'b1));
    oe_n = 1'b1; #1; check("R9", W'(bus_oe), W'(1'b0));
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule